// File: doc/BRIEF.md
# One-Shot Switch-Triggered LED Timer

This block drives a single LED from a single switch. When the switch is pressed while the block is idle, the LED lights for a fixed number of clock cycles and then goes dark by itself. A switch that stays held after the pulse keeps the LED dark. Another pulse can only start after the switch has been let go and pressed again. The switch level is taken to be clean and already synchronous to the clock.

The block is a Moore machine with three states: idle, lit, and waiting for the switch to be released. The LED is decoded from the state register alone, so every change in the LED follows the cause by one rising clock edge. A small counter, cleared while the machine is not lit, measures the length of the pulse. If the switch is released during the pulse, the pulse still runs to its full length, and the machine then goes straight back to idle.

Top module: `led_oneshot`

## Requirements
- R1: A synchronous active-high reset drives the LED low and puts the machine in idle after the next rising edge, whatever the switch is doing.
- R2: A switch sampled high (1) at a rising edge while idle makes the LED high from that edge onwards.
- R3: Once lit, the LED stays high for exactly PULSE_CYCLES clock periods (default 10), whatever the switch does in the meantime.
- R4: If the switch is still high when the pulse ends, the LED stays low for as long as the switch stays high.
- R5: After the switch has been sampled low, a new press starts a new full pulse.
- R6: A switch released during the pulse does not shorten it. The machine then returns to idle, so a press on the first cycle after the pulse ends lights the LED again.
- R7: The LED is a function of the state only. A change on the switch between clock edges never changes the LED before the next rising edge.
- R8: A reset asserted during a pulse ends it, and the LED is low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sw | input | 1 | Switch level, 1 = pressed, synchronous to clk |
| led | output | 1 | LED drive, 1 = lit |

## Verification
The checker assumes that the switch is a clean level that only changes away from the rising clock edge, so that each edge sees exactly one stable value. It also assumes that reset is held for at least one full edge. The bench changes the switch and reset only on falling edges, never presents a partial or bouncing press, and samples the LED on falling edges. The one exception is the mid-cycle probe for R7, which samples shortly after a falling-edge switch change and so still stays clear of any rising edge.

// File: rtl/led_oneshot.sv
module led_oneshot #(
  parameter int PULSE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sw,
  output logic led
);
  localparam int CNT_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

  typedef enum logic [1:0] {IDLE, LIT, HOLD} st_t;

  st_t st, st_n;
  logic [CNT_W-1:0] cnt;
  logic done;

  assign done = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) st <= IDLE;
    else     st <= st_n;
  end

  always_ff @(posedge clk) begin
    if (rst || st != LIT) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  always_comb begin
    st_n = st;
    case (st)
      IDLE: if (sw) st_n = LIT;
      LIT:  if (done) st_n = sw ? HOLD : IDLE;
      HOLD: if (!sw) st_n = IDLE;
      default: st_n = IDLE;
    endcase
  end

  assign led = (st == LIT);
endmodule

// File: rtl/led_oneshot_chk.sv
module led_oneshot_chk #(
  parameter int PULSE_CYCLES = 10
) (
  input logic clk,
  input logic rst,
  input logic sw,
  input logic led
);
  localparam int RW = $clog2(PULSE_CYCLES + 2) + 1;

  logic [RW-1:0] run;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= '0;
      armed <= 1'b1;
    end else begin
      run   <= led ? ((run == '1) ? run : run + 1'b1) : '0;
      armed <= !sw || (armed && !led);
    end
  end

  AST_RESET_DARK: assert property (@(posedge clk) rst |=> !led); // R1
  AST_RISE_NEEDS_PRESS: assert property (@(posedge clk) disable iff (rst) $rose(led) |-> $past(sw)); // R2
  AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (rst) ($fell(led) && !$past(rst)) |-> (run == RW'(PULSE_CYCLES))); // R3
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst) led |-> (run < RW'(PULSE_CYCLES))); // R3
  AST_REARM_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (rst) $rose(led) |-> $past(armed)); // R5
endmodule

bind led_oneshot led_oneshot_chk #(.PULSE_CYCLES(PULSE_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .sw(sw), .led(led)
);

// File: tb/led_oneshot_tb_top.sv
`timescale 1ns/1ps
module led_oneshot_tb_top;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw = 1'b0;
  logic led;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  led_oneshot #(.PULSE_CYCLES(N)) dut_i (.clk(clk), .rst(rst), .sw(sw), .led(led));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic count_pulse(input int rel_at, output int n);
    n = led ? 1 : 0;
    for (int i = 0; i < 3 * N && led; i++) begin
      if (i == rel_at) sw = 1'b0;
      tick();
      if (led) n++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; sw = 1'b1;
    tick(); tick();
    chk("R1 led low in reset", led, 0);
    sw = 1'b0; tick();
    rst = 1'b0; tick();
    chk("R1 idle after reset", led, 0);
  endtask

  task automatic t_press_hold();
    int n;
    sw = 1'b1; tick();
    chk("R2 press lights led", led, 1);
    count_pulse(-1, n);
    chk("R3 pulse length, held", n, N);
    n = 0;
    for (int i = 0; i < 15; i++) begin tick(); n += led; end
    chk("R4 dark while held", n, 0);
  endtask

  task automatic t_repress();
    int n;
    sw = 1'b0; tick(); tick();
    chk("R5 dark after release", led, 0);
    sw = 1'b1; tick();
    chk("R5 re-press lights led", led, 1);
    count_pulse(-1, n);
    chk("R5 second pulse length", n, N);
    sw = 1'b0; tick();
  endtask

  task automatic t_release_mid();
    int n;
    sw = 1'b1; tick();
    chk("R6 pulse start", led, 1);
    count_pulse(2, n);
    chk("R6 pulse not shortened", n, N);
    sw = 1'b1; tick();
    chk("R6 immediate re-press", led, 1);
    count_pulse(0, n);
    chk("R6 following pulse length", n, N);
    tick();
  endtask

  task automatic t_moore();
    int n;
    sw = 1'b0; tick();
    sw = 1'b1; #3;
    chk("R7 no mid-cycle rise", led, 0);
    tick();
    chk("R7 rise after edge", led, 1);
    sw = 1'b0; #3;
    chk("R7 no mid-cycle change in pulse", led, 1);
    count_pulse(-1, n);
    chk("R7 pulse length", n, N);
    tick();
  endtask

  task automatic t_reset_mid();
    sw = 1'b1; tick(); tick(); tick();
    chk("R8 lit before reset", led, 1);
    rst = 1'b1; tick();
    chk("R8 reset ends pulse", led, 0);
    sw = 1'b0; rst = 1'b0; tick();
    chk("R8 idle after reset", led, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_press_hold();
    t_repress();
    t_release_mid();
    t_moore();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule